// File: doc/BRIEF.md
# Wide-Register Bus Multiplexer with Atomic Shadows

This block sits between a narrow register bus and a set of control/status registers that are each wider than one bus word. The bus has an address, a read strobe and read data, and a write strobe and write data. Each register is given a run of consecutive bus addresses. A register can be readable, writable or both, and it can ask for its start address to be aligned to a power of two. The address map is worked out from parameters when the block is elaborated.

Reads and writes of a wide register are atomic. A read of the register's first word loads the whole value into a read shadow in that same cycle. The later words of that register are then served from the shadow, even if the register has changed in the meantime. Writes to every word except the last one only fill a write shadow. A write to the last word hands the full assembled value to the register in a single strobe.

The bus takes a new access every cycle. Read data comes back one cycle after the read strobe.

Top module: `csrmux_top`

## Requirements
- R1: Register i spans round_up(ceil(REG_WIDTH[i]/DATA_W), 2^ALIGN) words. Registers are placed in index order. Each start address is the next free address rounded up to a multiple of 2^max(ALIGN, REG_ALIGN[i]). With the defaults (DATA_W 8, ALIGN 0, widths 4/8/16/20/12, alignment requests 0/0/0/3/0), the map is 0, 1, 2–3, 8–10 and 11–12. Register i occupies the bits of the flat buses starting at the sum of the widths of registers 0..i-1, so the defaults place them at bit offsets 0, 4, 12, 28 and 48.
- R2: A read at a readable register's lowest address raises that register's bit of `reg_rstb` in the same cycle. A read at any of its higher addresses raises no read strobe.
- R3: In the cycle after `bus_rstb`, `bus_rdata` carries the addressed word, with word k holding register bits [8k+7:8k] for the default 8-bit data. In a cycle that follows no read, `bus_rdata` is zero.
- R4: A read of a register's lowest word captures the whole register at that moment. Reads of its higher words return the captured value, whatever the register holds later.
- R5: A write to any word of a writable register other than its last word raises no write strobe. The word is kept for the later commit.
- R6: A write to a writable register's last address raises that register's `reg_wstb` bit for exactly one cycle, in the next cycle. Alongside it, `reg_wdata` carries the stored lower words combined with the final word, truncated to the register width.
- R7: `REG_ACC` bit 0 means readable and bit 1 means writable. A write to a register that is not writable raises no strobe. A read of a register that is not readable raises no read strobe and returns zero.
- R8: A read of an address that belongs to no register returns zero, and a write to such an address raises no strobe.
- R9: An access can be issued every cycle with a new address, and a read and a write can be given in the same cycle. Each of them then behaves as if issued alone.
- R10: While `rst_n` is low, and right after it rises, `bus_rdata`, `reg_rstb` and `reg_wstb` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Bus word address |
| bus_rstb | input | 1 | Bus read request |
| bus_rdata | output | DATA_W | Read word, valid the cycle after the request |
| bus_wstb | input | 1 | Bus write request |
| bus_wdata | input | DATA_W | Bus write word |
| reg_rdata | input | TOTAL_W | Current values of all registers, packed |
| reg_rstb | output | NREG | Per-register read strobe |
| reg_wstb | output | NREG | Per-register write strobe |
| reg_wdata | output | TOTAL_W | Committed write values, packed |

## Verification
Two things can happen in the same cycle: a read that captures one register's value on its first word, and a write that commits another register (or the same one) on its last word. They are also paired with shadow-word reads and writes that hit neighbouring registers. The bench provokes these overlaps with random streams in which both strobes are set independently in every cycle, over all mapped addresses, the alignment gap, and addresses beyond the map. A bench model holds its own read and write shadows, computed from the requirements. It judges every cycle's read strobes in that cycle, and it judges the read word, write strobes and committed value one cycle later.

// File: rtl/csrmux_pkg.sv
package csrmux_pkg;

  // access code: bit 0 readable, bit 1 writable
  localparam logic [1:0] ACC_R  = 2'b01;
  localparam logic [1:0] ACC_W  = 2'b10;
  localparam logic [1:0] ACC_RW = 2'b11;

  // number of bus words needed for a register of the given width
  function automatic int unsigned words_of(int unsigned width, int unsigned dw);
    return (width + dw - 1) / dw;
  endfunction

  // round v up to a multiple of 2**lg
  function automatic int unsigned round_up(int unsigned v, int unsigned lg);
    int unsigned g;
    g = 32'd1 << lg;
    return ((v + g - 1) / g) * g;
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/csrmux_slot.sv
module csrmux_slot #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned BASE   = 0,
  parameter int unsigned SPAN   = 2,
  parameter logic [1:0]  ACC    = 2'b11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rstb,
  input  logic              bus_wstb,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [WIDTH-1:0]  reg_rdata,
  output logic              reg_rstb,
  output logic              reg_wstb,
  output logic [WIDTH-1:0]  reg_wdata,
  output logic              rd_hit,
  output logic [DATA_W-1:0] rd_word
);

  localparam int unsigned SH_W  = SPAN * DATA_W;
  localparam int unsigned SEL_W = (SPAN > 1) ? $clog2(SPAN) : 1;

  // address decode: offset into this register, wraps high when below BASE
  logic [ADDR_W:0]    off;
  logic               in_range;
  logic               at_base;
  logic               at_last;
  logic [SEL_W-1:0]   sel;
  int unsigned        shamt;

  assign off      = {1'b0, bus_addr} - (ADDR_W + 1)'(BASE);
  assign in_range = off < (ADDR_W + 1)'(SPAN);
  assign at_base  = in_range && (off == '0);
  assign at_last  = in_range && (off == (ADDR_W + 1)'(SPAN - 1));
  assign sel      = off[SEL_W-1:0];
  assign shamt    = int'(sel) * DATA_W;

  // replace the selected word of a shadow image with the bus word
  function automatic logic [SH_W-1:0] merge_word(logic [SH_W-1:0] img,
                                                 int unsigned sh,
                                                 logic [DATA_W-1:0] w);
    logic [SH_W-1:0] mask;
    mask = SH_W'({DATA_W{1'b1}}) << sh;
    return (img & ~mask) | (SH_W'(w) << sh);
  endfunction

  generate
    if (ACC[0]) begin : g_rd
      logic [SH_W-1:0] rd_shadow;
      logic [SH_W-1:0] padded;

      assign padded   = SH_W'(reg_rdata);
      assign reg_rstb = bus_rstb && at_base;
      assign rd_hit   = bus_rstb && in_range;
      // lowest word comes straight from the register, the rest from the capture
      assign rd_word  = at_base ? padded[DATA_W-1:0] : DATA_W'(rd_shadow >> shamt);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rd_shadow <= '0;
        else if (reg_rstb) rd_shadow <= padded;
      end
    end else begin : g_no_rd
      logic unused_rd;
      assign unused_rd = ^{reg_rdata, bus_rstb, at_base};
      assign reg_rstb  = 1'b0;
      assign rd_hit    = 1'b0;
      assign rd_word   = '0;
    end

    if (ACC[1]) begin : g_wr
      logic [SH_W-1:0] wr_shadow;
      logic [SH_W-1:0] merged;

      assign merged = merge_word(wr_shadow, shamt, bus_wdata);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          wr_shadow <= '0;
          reg_wstb  <= 1'b0;
          reg_wdata <= '0;
        end else begin
          reg_wstb <= bus_wstb && at_last;
          if (bus_wstb && in_range) begin
            if (at_last) reg_wdata <= WIDTH'(merged);
            else         wr_shadow <= merged;
          end
        end
      end

      assert_commit_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wstb |-> $past(bus_wstb && at_last));
    end else begin : g_no_wr
      logic unused_wr;
      assign unused_wr = ^{bus_wdata, bus_wstb, at_last};
      assign reg_wstb  = 1'b0;
      assign reg_wdata = '0;
    end
  endgenerate

endmodule

// File: rtl/csrmux_rdmux.sv
module csrmux_rdmux #(
  parameter int unsigned NREG   = 5,
  parameter int unsigned DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NREG-1:0]          hit,
  input  logic [NREG*DATA_W-1:0]   words,
  output logic [DATA_W-1:0]        rdata
);

  logic [DATA_W-1:0] sel_word;

  always_comb begin
    sel_word = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit[i]) sel_word = sel_word | words[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= sel_word;
  end

  // address ranges must never overlap
  assert_single_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

endmodule

// File: rtl/csrmux_top.sv
module csrmux_top
  import csrmux_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NREG   = 5,
  parameter int unsigned ALIGN  = 0,
  parameter int unsigned REG_WIDTH [NREG] = '{4, 8, 16, 20, 12},
  parameter logic [1:0]  REG_ACC   [NREG] = '{ACC_R, ACC_W, ACC_RW, ACC_RW, ACC_R},
  parameter int unsigned REG_ALIGN [NREG] = '{0, 0, 0, 3, 0},
  localparam int unsigned TOTAL_W = 60
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_rstb,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                bus_wstb,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic [TOTAL_W-1:0]  reg_rdata,
  output logic [NREG-1:0]     reg_rstb,
  output logic [NREG-1:0]     reg_wstb,
  output logic [TOTAL_W-1:0]  reg_wdata
);

  // words occupied by register i, padded to the global alignment
  function automatic int unsigned span_of(int unsigned i);
    return round_up(words_of(REG_WIDTH[i], DATA_W), ALIGN);
  endfunction

  // start address of register i in allocation order
  function automatic int unsigned base_of(int unsigned i);
    int unsigned nxt;
    int unsigned res;
    nxt = 0;
    res = 0;
    for (int unsigned k = 0; k <= i; k++) begin
      nxt = round_up(nxt, max_u(ALIGN, REG_ALIGN[k]));
      if (k == i) res = nxt;
      nxt = nxt + span_of(k);
    end
    return res;
  endfunction

  // lowest bit of register i in the packed buses
  function automatic int unsigned bit_off(int unsigned i);
    int unsigned s;
    s = 0;
    for (int unsigned k = 0; k < i; k++) s = s + REG_WIDTH[k];
    return s;
  endfunction

  logic [NREG-1:0]        rd_hit;
  logic [NREG*DATA_W-1:0] rd_words;

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_slot
      localparam int unsigned W   = REG_WIDTH[i];
      localparam int unsigned OFF = bit_off(i);

      csrmux_slot #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .WIDTH  (W),
        .BASE   (base_of(i)),
        .SPAN   (span_of(i)),
        .ACC    (REG_ACC[i])
      ) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rstb  (bus_rstb),
        .bus_wstb  (bus_wstb),
        .bus_wdata (bus_wdata),
        .reg_rdata (reg_rdata[OFF +: W]),
        .reg_rstb  (reg_rstb[i]),
        .reg_wstb  (reg_wstb[i]),
        .reg_wdata (reg_wdata[OFF +: W]),
        .rd_hit    (rd_hit[i]),
        .rd_word   (rd_words[i*DATA_W +: DATA_W])
      );
    end
  endgenerate

  csrmux_rdmux #(
    .NREG   (NREG),
    .DATA_W (DATA_W)
  ) u_rdmux (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (rd_hit),
    .words (rd_words),
    .rdata (bus_rdata)
  );

  assert_one_rstb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_rstb));

  assert_one_wstb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_wstb));

  assert_rdata_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rstb) |-> (bus_rdata == '0));

  assert_wstb_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wstb != '0) |-> $past(bus_wstb));

endmodule

// File: tb/tb_csrmux_top.sv
module tb_csrmux_top;

  localparam int CLK_PERIOD = 10;
  localparam int NR = 5;
  localparam int BASE [NR] = '{0, 1, 2, 8, 11};
  localparam int SPAN [NR] = '{1, 1, 2, 3, 2};
  localparam int WID  [NR] = '{4, 8, 16, 20, 12};
  localparam int OFFS [NR] = '{0, 4, 12, 28, 48};
  localparam logic [1:0] ACC [NR] = '{2'b01, 2'b10, 2'b11, 2'b11, 2'b01};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_rstb = 1'b0;
  logic [7:0]  bus_rdata;
  logic        bus_wstb = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [59:0] reg_rdata;
  logic [4:0]  reg_rstb;
  logic [4:0]  reg_wstb;
  logic [59:0] reg_wdata;

  logic [31:0] regval [NR];
  logic [31:0] rsh [NR];
  logic [31:0] wsh [NR];

  int nvec = 0;
  int nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csrmux_top dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rstb(bus_rstb),
    .bus_rdata(bus_rdata), .bus_wstb(bus_wstb), .bus_wdata(bus_wdata),
    .reg_rdata(reg_rdata), .reg_rstb(reg_rstb), .reg_wstb(reg_wstb),
    .reg_wdata(reg_wdata)
  );

  function automatic logic [31:0] wmask(int i);
    return (32'd1 << WID[i]) - 32'd1;
  endfunction

  always_comb begin
    logic [63:0] acc;
    acc = '0;
    for (int i = 0; i < NR; i++) acc = acc | (64'(regval[i] & wmask(i)) << OFFS[i]);
    reg_rdata = acc[59:0];
  end

  function automatic logic [31:0] wslice(int i);
    return 32'(64'(reg_wdata) >> OFFS[i]) & wmask(i);
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    nvec++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // one bus cycle; called at a falling edge, returns at the next falling edge
  task automatic op(input string tag, input logic [7:0] a, input bit r,
                    input bit w, input logic [7:0] d);
    logic [4:0]  exp_rs;
    logic [4:0]  exp_ws;
    logic [7:0]  exp_rd;
    logic [31:0] exp_wd [NR];
    bus_addr = a; bus_rstb = r; bus_wstb = w; bus_wdata = d;
    #1;
    exp_rs = '0; exp_ws = '0; exp_rd = '0;
    for (int i = 0; i < NR; i++) begin
      int o;
      logic [31:0] m;
      exp_wd[i] = '0;
      o = int'(a) - BASE[i];
      if (o >= 0 && o < SPAN[i]) begin
        if (r && ACC[i][0]) begin
          if (o == 0) begin
            exp_rs[i] = 1'b1;
            rsh[i] = regval[i] & wmask(i);
          end
          exp_rd = 8'(rsh[i] >> (8 * o));
        end
        if (w && ACC[i][1]) begin
          m = (wsh[i] & ~(32'hff << (8 * o))) | (32'(d) << (8 * o));
          if (o == SPAN[i] - 1) begin
            exp_ws[i] = 1'b1;
            exp_wd[i] = m & wmask(i);
          end else wsh[i] = m;
        end
      end
    end
    chk({tag, " R2 rstb"}, 64'(reg_rstb), 64'(exp_rs));
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R3 rdata"}, 64'(bus_rdata), 64'(exp_rd));
    chk({tag, " R6 wstb"}, 64'(reg_wstb), 64'(exp_ws));
    for (int i = 0; i < NR; i++)
      if (exp_ws[i]) chk({tag, " R6 wdata"}, 64'(wslice(i)), 64'(exp_wd[i]));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NR; i++) begin
      regval[i] = '0; rsh[i] = '0; wsh[i] = '0;
    end
    regval[0] = 32'ha; regval[2] = 32'h5aa5; regval[3] = 32'h12345; regval[4] = 32'habc;
    repeat (3) @(negedge clk);
    chk("R10 rdata in reset", 64'(bus_rdata), 64'd0);
    chk("R10 wstb in reset", 64'(reg_wstb), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 rstb after reset", 64'(reg_rstb), 64'd0);
    chk("R10 rdata after reset", 64'(bus_rdata), 64'd0);

    // R2/R3: two-word read, low then high word
    op("R2", 8'd2, 1, 0, 8'h00);
    chk("R3 low word", 64'(bus_rdata), 64'ha5);
    op("R2", 8'd3, 1, 0, 8'h00);
    chk("R3 high word", 64'(bus_rdata), 64'h5a);
    op("R3", 8'd0, 1, 0, 8'h00);
    chk("R3 narrow reg", 64'(bus_rdata), 64'h0a);
    op("R3", 8'd0, 0, 0, 8'h00);
    chk("R3 idle zero", 64'(bus_rdata), 64'h0);

    // R4: capture on first word, register changes before later words
    op("R4", 8'd8, 1, 0, 8'h00);
    regval[3] = 32'hfedcb;
    op("R4", 8'd9, 1, 0, 8'h00);
    chk("R4 captured mid word", 64'(bus_rdata), 64'h23);
    op("R4", 8'd10, 1, 0, 8'h00);
    chk("R4 captured top word", 64'(bus_rdata), 64'h01);
    op("R4", 8'd11, 1, 0, 8'h00);
    chk("R4 12-bit low", 64'(bus_rdata), 64'hbc);
    op("R4", 8'd12, 1, 0, 8'h00);
    chk("R4 12-bit high", 64'(bus_rdata), 64'h0a);

    // R5/R6: multi-word write commit
    op("R5", 8'd2, 0, 1, 8'h55);
    chk("R5 no strobe on low word", 64'(reg_wstb), 64'd0);
    op("R6", 8'd3, 0, 1, 8'haa);
    chk("R6 strobe", 64'(reg_wstb), 64'b00100);
    chk("R6 value", 64'(wslice(2)), 64'haa55);
    op("R6", 8'd3, 0, 0, 8'h00);
    chk("R6 one cycle", 64'(reg_wstb), 64'd0);
    op("R5", 8'd8, 0, 1, 8'h55);
    op("R5", 8'd9, 0, 1, 8'haa);
    chk("R5 no strobe mid word", 64'(reg_wstb), 64'd0);
    op("R6", 8'd10, 0, 1, 8'h33);
    chk("R6 truncated", 64'(wslice(3)), 64'h3aa55);
    op("R6", 8'd1, 0, 1, 8'h3d);
    chk("R6 single word", 64'(wslice(1)), 64'h3d);

    // R7: access restrictions
    op("R7", 8'd0, 0, 1, 8'hff);
    chk("R7 write to read-only", 64'(reg_wstb), 64'd0);
    op("R7", 8'd1, 1, 0, 8'h00);
    chk("R7 read of write-only", 64'(bus_rdata), 64'd0);

    // R8: unmapped addresses, inside the alignment gap and beyond the map
    op("R8", 8'd5, 1, 1, 8'h77);
    chk("R8 gap read", 64'(bus_rdata), 64'd0);
    chk("R8 gap write", 64'(reg_wstb), 64'd0);
    op("R8", 8'd200, 1, 1, 8'h77);
    chk("R8 far read", 64'(bus_rdata), 64'd0);

    // R9: read capture and write commit in the same cycle
    op("R9", 8'd2, 0, 1, 8'h11);
    regval[3] = 32'h0beef;
    op("R9", 8'd3, 1, 1, 8'h22);
    op("R9", 8'd8, 1, 1, 8'h44);

    // R9: random back-to-back traffic with overlapping strobes
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] a;
      if (($urandom % 8) == 0) regval[$urandom % NR] = $urandom;
      a = (($urandom % 16) == 0) ? 8'($urandom) : 8'($urandom % 16);
      op("R9 rnd", a, 1'($urandom), 1'($urandom), 8'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule